// File: doc/BRIEF.md
# ADC result output formatter with overrange saturation

This block sits at the digital edge of a 10-bit analog-to-digital converter. Each cycle the converter core may present an 11-bit internal result together with a strobe. The block captures that result on the rising clock edge and presents it on an output bus. The bus carries a 10-bit straight-binary code field, a separate overrange flag and a data-valid signal.

A result of 1024 or more is above positive full scale. In that case the block raises the overrange flag and forces every bit of the code field to 1 for as long as the flag stays set. Results below 1024 pass into the code field unchanged.

A high-impedance request input releases the eleven data and flag outputs so that another agent can drive a shared bus. This is a combinational path. The registered contents are kept, and data-valid stays driven.

Top module: `adc_out_fmt`

## Requirements
- R1: While rst_ni is low, code_o, ovr_o and vld_o are all 0 (asynchronous, active-low reset).
- R2: On a rising edge where res_vld_i is 1 and res_i is below 1024, code_o takes res_i[9:0] and ovr_o takes 0 one cycle later. The code field is straight binary, with bit 0 as the LSB.
- R3: On a rising edge where res_vld_i is 1 and res_i is 1024 or more (bit 10 set), ovr_o becomes 1 and all ten bits of code_o become 1. While ovr_o is 1, code_o stays all ones.
- R4: A captured result of 0 gives code_o = 0000000000 with ovr_o = 0. A captured result of 512 gives code_o = 1000000000, which is bit 9 set.
- R5: vld_o equals res_vld_i as sampled at the previous rising edge. hiz_i has no effect on it.
- R6: On a rising edge where res_vld_i is 0, code_o and ovr_o keep their previous values.
- R7: While hiz_i is 1, all ten code_o bits and ovr_o are high impedance. This follows hiz_i without waiting for a clock edge.
- R8: hiz_i does not alter the registered code and flag. When hiz_i returns to 0, the values captured so far reappear at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; capture on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | CODE_W+1 | Internal converter result; bit CODE_W set means overrange |
| res_vld_i | input | 1 | Strobe marking res_i as a new result |
| hiz_i | input | 1 | 1 releases code_o and ovr_o to high impedance |
| code_o | output | CODE_W | Straight-binary code field, saturated on overrange |
| ovr_o | output | 1 | Overrange flag |
| vld_o | output | 1 | Registered copy of res_vld_i |

## Verification
The bench builds the block with the default CODE_W of 10, so the full 11-bit result space from 0 to 2047 can be reached. That space includes the 1023/1024 boundary, half scale and the saturation region. The code and flag outputs are observed through pulled-up nets. A released bus therefore reads as all ones even when the registered code holds zeros. This separates a real release from a value that is still being driven.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned DEF_CODE_W = 10;

  function automatic int unsigned res_width(input int unsigned code_w);
    return code_w + 1;
  endfunction
endpackage

// File: rtl/adc_fmt_sat.sv
module adc_fmt_sat #(
  parameter int unsigned CODE_W = adc_fmt_pkg::DEF_CODE_W,
  localparam int unsigned RES_W = adc_fmt_pkg::res_width(CODE_W)
) (
  input  logic [RES_W-1:0]  res_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ovr_o
);
  // bit CODE_W set means the result reached 2**CODE_W or more
  assign ovr_o = res_i[CODE_W];

  for (genvar i = 0; i < CODE_W; i++) begin : g_sat
    assign code_o[i] = res_i[i] | ovr_o;
  end
endmodule

// File: rtl/adc_fmt_reg.sv
module adc_fmt_reg #(
  parameter int unsigned CODE_W = adc_fmt_pkg::DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ovr_i,
  output logic [CODE_W-1:0] code_q_o,
  output logic              ovr_q_o,
  output logic              vld_q_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q_o <= '0;
      ovr_q_o  <= 1'b0;
      vld_q_o  <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      vld_q_o <= ld_i;
      armed_q <= 1'b1;
      if (ld_i) begin
        code_q_o <= code_i;
        ovr_q_o  <= ovr_i;
      end
    end
  end

  p_vld_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    vld_q_o == $past(ld_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !$past(ld_i) |-> ($stable(code_q_o) && $stable(ovr_q_o)));
endmodule

// File: rtl/adc_fmt_drv.sv
module adc_fmt_drv #(
  parameter int unsigned CODE_W = adc_fmt_pkg::DEF_CODE_W
) (
  input  logic              hiz_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ovr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ovr_o
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_pad
    assign code_o[i] = hiz_i ? 1'bz : code_i[i];
  end

  assign ovr_o = hiz_i ? 1'bz : ovr_i;
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int unsigned CODE_W = adc_fmt_pkg::DEF_CODE_W,
  localparam int unsigned RES_W = adc_fmt_pkg::res_width(CODE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RES_W-1:0]  res_i,
  input  logic              res_vld_i,
  input  logic              hiz_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ovr_o,
  output logic              vld_o
);
  logic [CODE_W-1:0] sat_code;
  logic              sat_ovr;
  logic [CODE_W-1:0] code_q;
  logic              ovr_q;
  logic              chk_armed_q;

  adc_fmt_sat #(.CODE_W(CODE_W)) u_sat (
    .res_i  (res_i),
    .code_o (sat_code),
    .ovr_o  (sat_ovr)
  );

  adc_fmt_reg #(.CODE_W(CODE_W)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (res_vld_i),
    .code_i   (sat_code),
    .ovr_i    (sat_ovr),
    .code_q_o (code_q),
    .ovr_q_o  (ovr_q),
    .vld_q_o  (vld_o)
  );

  adc_fmt_drv #(.CODE_W(CODE_W)) u_drv (
    .hiz_i  (hiz_i),
    .code_i (code_q),
    .ovr_i  (ovr_q),
    .code_o (code_o),
    .ovr_o  (ovr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_armed_q <= 1'b0;
    else         chk_armed_q <= 1'b1;
  end

  p_sat_all_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> (&code_q));

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_armed_q)
    ($past(res_vld_i) && !$past(res_i[CODE_W])) |->
      (code_q == $past(res_i[CODE_W-1:0]) && !ovr_q));

  p_ovr_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_armed_q)
    ($past(res_vld_i) && $past(res_i[CODE_W])) |-> ovr_q);
endmodule

// File: tb/adc_out_fmt_test.sv
module adc_out_fmt_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW:0]   res = '0;
  logic          res_vld = 1'b0;
  logic          hiz = 1'b0;
  tri1  [CW-1:0] code_w;
  tri1           ovr_w;
  logic          vld_w;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [CW-1:0] m_code = '0;
  logic          m_ovr  = 1'b0;
  logic          m_vld  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_fmt #(.CODE_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .res_vld_i(res_vld),
    .hiz_i(hiz), .code_o(code_w), .ovr_o(ovr_w), .vld_o(vld_w)
  );

  function automatic logic [CW-1:0] exp_code(input logic [CW:0] r);
    return (r >= 11'd1024) ? '1 : r[CW-1:0];
  endfunction

  function automatic logic exp_ovr(input logic [CW:0] r);
    return r >= 11'd1024;
  endfunction

  task automatic check(input string req);
    logic [CW-1:0] ec;
    logic          eo;
    // released bus reads as pulled-up ones
    ec = hiz ? '1 : m_code;
    eo = hiz ? 1'b1 : m_ovr;
    total++;
    if (code_w !== ec || ovr_w !== eo || vld_w !== m_vld) begin
      bad++;
      $display("FAIL %s: code=%h ovr=%b vld=%b expected code=%h ovr=%b vld=%b",
               req, code_w, ovr_w, vld_w, ec, eo, m_vld);
    end
  endtask

  // drive at falling edge, model the rising edge, check at next falling edge
  task automatic cyc(input logic [CW:0] r, input logic v, input logic z, input string req);
    res = r; res_vld = v; hiz = z;
    @(posedge clk);
    m_vld = v;
    if (v) begin
      m_code = exp_code(r);
      m_ovr  = exp_ovr(r);
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    res = 11'h7ff; res_vld = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    res_vld = 1'b0;

    cyc(11'd0,    1'b1, 1'b0, "R4 zero");
    cyc(11'd512,  1'b1, 1'b0, "R4 half scale");
    cyc(11'd1023, 1'b1, 1'b0, "R2 top in range");
    cyc(11'd1024, 1'b1, 1'b0, "R3 first overrange");
    cyc(11'd5,    1'b0, 1'b0, "R6 hold with strobe low");
    cyc(11'd2047, 1'b1, 1'b0, "R3 max overrange");
    cyc(11'd1100, 1'b0, 1'b0, "R6 hold overrange");
    cyc(11'd341,  1'b1, 1'b0, "R2 pattern");
    cyc(11'd0,    1'b1, 1'b0, "R4 zero again");
    hiz = 1'b1;
    #1;
    total++;
    if (code_w !== '1 || ovr_w !== 1'b1) begin
      bad++;
      $display("FAIL R7 release without clock: code=%h ovr=%b expected code=3ff ovr=1", code_w, ovr_w);
    end
    cyc(11'd0,    1'b0, 1'b1, "R7 released bus");
    cyc(11'd0,    1'b1, 1'b1, "R5 valid while released");
    cyc(11'd0,    1'b0, 1'b0, "R8 contents after release");
    cyc(11'd1500, 1'b1, 1'b1, "R7 capture while released");
    cyc(11'd0,    1'b0, 1'b0, "R8 overrange after release");
    cyc(11'd512,  1'b1, 1'b0, "R3 overrange clears");

    for (int i = 0; i < 3000; i++) begin
      logic [CW:0] r;
      r = 11'($urandom);
      cyc(r, 1'($urandom), ($urandom % 8) == 0, "R2 R3 R5 R6 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule